// File: doc/BRIEF.md
# Timer Interrupt Router with Legacy Takeover

This block sits between a bank of timer channels and the interrupt fabric. Each cycle it takes the fire strobes of the channels and turns them into interrupt activity. Each channel is set up by its own delivery controls:

- a route field that picks one of the wired interrupt lines;
- a delivery style, either level or edge;
- a message enable that swaps the wired line for a 32-bit memory-write request.

The block also keeps one status bit per channel, which is set while a level interrupt is pending.

A legacy takeover mode moves channel 0 onto line 0 and channel 1 onto line 8, whatever their route fields hold. In that mode the block takes those two lines away from two external legacy sources: a periodic timer and a clock source. While the mode is on, the external timer is told to stop through an enable output. When the mode is left, the external timer is enabled again and line 8 goes back to the last recorded level of the clock source.

Message requests are held on the output until they are acknowledged. Only one request per channel can be waiting or in flight. When several channels are waiting, the lowest-numbered channel is issued first.

Top module: `timer_irq_router`

## Requirements
- R1: With `legacy_i` high, channel 0 drives line 0 and channel 1 drives line 8 whatever their route fields hold; with it low, and for every other channel always, the 5-bit route field `ch_route_i[c*5 +: 5]` picks the line.
- R2: A fire on an enabled, level-style channel (`ch_level_i[c]`=1) without message delivery sets `status_o[c]` after the next clock edge. It holds the routed line high until the channel is cleared.
- R3: A fire on an enabled, edge-style channel (`ch_level_i[c]`=0) without message delivery raises its routed line for exactly one cycle, starting after the next clock edge, and leaves `status_o[c]` at 0.
- R4: A low `glb_en_i`, a low `ch_en_i[c]` or a high `clr_i[c]` clears `status_o[c]` and lowers the channel's line at the next edge. A fire in that cycle has no effect.
- R5: A fire on an enabled channel with `ch_msg_en_i[c]`=1 drives no line. Two edges later it raises `msg_req_o`, with `msg_data_o` = `ch_msg_i[c*64 +: 32]` and `msg_addr_o` = `ch_msg_i[c*64+32 +: 32]`. The request and its fields stay stable until the edge at which `msg_ack_i` is high.
- R6: Setting `ch_msg_en_i[c]` clears a pending level interrupt of channel c, and its line, at the next edge.
- R7: While `legacy_i` is high, `lgc_tmr_en_o` is low from the next edge on, and the external levels no longer reach lines 0 and 8.
- R8: After `legacy_i` falls, `lgc_tmr_en_o` is high again from the next edge. Line 8 shows the clock-source level that was recorded while the mode was on.
- R9: Outside legacy mode, `lgc_tmr_lvl_i` reaches line 0 in the same cycle. `lgc_clk_lvl_i` is recorded on every edge and reaches line 8 one cycle later. Reset clears the recorded level.
- R10: A fire on a channel whose message is still waiting or in flight is dropped. Waiting messages are issued lowest channel first.
- R11: After reset all lines, status bits and `msg_req_o` are low and `lgc_tmr_en_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fire_i | input | N_CH | Per-channel fire strobe |
| clr_i | input | N_CH | Per-channel clear request |
| glb_en_i | input | 1 | Global interrupt enable |
| legacy_i | input | 1 | Legacy takeover mode |
| ch_en_i | input | N_CH | Channel interrupt enable |
| ch_level_i | input | N_CH | 1 = level delivery, 0 = edge delivery |
| ch_msg_en_i | input | N_CH | Message delivery enable |
| ch_route_i | input | N_CH*RW | Packed line route fields |
| ch_msg_i | input | N_CH*(AW+DW) | Packed message fields: data low, address high |
| lgc_tmr_lvl_i | input | 1 | External legacy timer level |
| lgc_clk_lvl_i | input | 1 | External clock-source level |
| msg_ack_i | input | 1 | Message write accepted |
| irq_o | output | N_LINES | Interrupt lines |
| status_o | output | N_CH | Per-channel pending status |
| lgc_tmr_en_o | output | 1 | Enable for the external legacy timer |
| msg_req_o | output | 1 | Message write request |
| msg_addr_o | output | AW | Message write address |
| msg_data_o | output | DW | Message write data |

## Verification
The router is tried with single fires in level, edge and message style on channels with distinct route fields. The resulting line pattern separates held lines from one-cycle pulses, and separates wired delivery from message delivery. The same channels are fired with legacy mode off and then on. This shows whether the route field or the fixed legacy lines decide where channels 0 and 1 go. Toggles of the external levels across mode changes show passthrough, muting and the restoring of the recorded clock level. Simultaneous and repeated message fires with a delayed acknowledge show the issue order, that fields are held stable, and that duplicate requests are dropped.

// File: rtl/timer_irq_router.sv
module timer_irq_router #(
  parameter int N_CH    = 4,
  parameter int N_LINES = 24,
  parameter int RW      = 5,
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int LEG_A   = 0,
  parameter int LEG_B   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_CH-1:0]          fire_i,
  input  logic [N_CH-1:0]          clr_i,
  input  logic                     glb_en_i,
  input  logic                     legacy_i,
  input  logic [N_CH-1:0]          ch_en_i,
  input  logic [N_CH-1:0]          ch_level_i,
  input  logic [N_CH-1:0]          ch_msg_en_i,
  input  logic [N_CH*RW-1:0]       ch_route_i,
  input  logic [N_CH*(AW+DW)-1:0]  ch_msg_i,
  input  logic                     lgc_tmr_lvl_i,
  input  logic                     lgc_clk_lvl_i,
  input  logic                     msg_ack_i,
  output logic [N_LINES-1:0]       irq_o,
  output logic [N_CH-1:0]          status_o,
  output logic                     lgc_tmr_en_o,
  output logic                     msg_req_o,
  output logic [AW-1:0]            msg_addr_o,
  output logic [DW-1:0]            msg_data_o
);
  localparam int MW = AW + DW;
  localparam int CW = (N_CH > 1) ? $clog2(N_CH) : 1;
  localparam logic [RW-1:0] LINE_A = RW'(LEG_A);
  localparam logic [RW-1:0] LINE_B = RW'(LEG_B);

  logic [N_CH-1:0] status_q, pulse_q, pend_q;
  logic            busy_q, clk_lvl_q, tmr_en_q;
  logic [CW-1:0]   cur_q, sel;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   data_q;

  logic [N_CH-1:0] deliver, kill, msg_new, load_mask, inflight;
  logic            load;
  logic [N_LINES-1:0] lines;

  assign deliver = fire_i & ch_en_i & {N_CH{glb_en_i}} & ~clr_i;
  assign kill    = ~ch_en_i | {N_CH{~glb_en_i}} | clr_i | ch_msg_en_i;
  assign msg_new = deliver & ch_msg_en_i;

  always_comb begin
    sel = '0;
    for (int c = N_CH - 1; c >= 0; c--)
      if (pend_q[c]) sel = CW'(c);
  end

  assign load      = !busy_q && (|pend_q);
  assign load_mask = load ? (N_CH'(1) << sel) : '0;
  assign inflight  = busy_q ? (N_CH'(1) << cur_q) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q  <= '0;
      pulse_q   <= '0;
      pend_q    <= '0;
      busy_q    <= 1'b0;
      cur_q     <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      clk_lvl_q <= 1'b0;
      tmr_en_q  <= 1'b1;
    end else begin
      status_q  <= (status_q & ~kill) | (deliver & ch_level_i & ~ch_msg_en_i);
      pulse_q   <= deliver & ~ch_level_i & ~ch_msg_en_i;
      pend_q    <= (pend_q & ~load_mask) | (msg_new & ~pend_q & ~inflight & ~load_mask);
      clk_lvl_q <= lgc_clk_lvl_i;
      tmr_en_q  <= !legacy_i;
      if (load) begin
        busy_q <= 1'b1;
        cur_q  <= sel;
        data_q <= ch_msg_i[int'(sel)*MW +: DW];
        addr_q <= ch_msg_i[int'(sel)*MW + DW +: AW];
      end else if (busy_q && msg_ack_i) begin
        busy_q <= 1'b0;
      end
    end
  end

  always_comb begin
    logic [RW-1:0] r;
    lines = '0;
    for (int c = 0; c < N_CH; c++) begin
      r = ch_route_i[c*RW +: RW];
      if (legacy_i && c == 0) r = LINE_A;
      if (legacy_i && c == 1) r = LINE_B;
      if ((status_q[c] || pulse_q[c]) && int'(r) < N_LINES) lines[r] = 1'b1;
    end
    lines[LEG_A] = lines[LEG_A] | (!legacy_i && lgc_tmr_lvl_i);
    lines[LEG_B] = lines[LEG_B] | (!legacy_i && clk_lvl_q);
  end

  assign irq_o        = lines;
  assign status_o     = status_q;
  assign lgc_tmr_en_o = tmr_en_q;
  assign msg_req_o    = busy_q;
  assign msg_addr_o   = addr_q;
  assign msg_data_o   = data_q;

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_req_o && !msg_ack_i) |=> (msg_req_o && $stable(msg_addr_o) && $stable(msg_data_o)));

  p_legacy_mute_r7: assert property (@(posedge clk) disable iff (!rst_n)
    legacy_i |=> !lgc_tmr_en_o);

  p_clk_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lgc_clk_lvl_i && !legacy_i) |=> (legacy_i || irq_o[LEG_B]));

  generate
    for (genvar g = 0; g < N_CH; g++) begin : g_chk
      p_level_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i[g] && ch_en_i[g] && glb_en_i && !clr_i[g] && ch_level_i[g] && !ch_msg_en_i[g])
        |=> status_o[g]);
      p_edge_nostat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ch_level_i[g] && !status_o[g]) |=> !status_o[g]);
      p_off_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_en_i || !ch_en_i[g] || clr_i[g]) |=> !status_o[g]);
      p_msg_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ch_msg_en_i[g] |=> !status_o[g]);
    end
  endgenerate
endmodule

// File: tb/timer_irq_router_bench.sv
module timer_irq_router_bench;
  localparam int N = 4, L = 24, RW = 5;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] fire = 0, clr = 0, en = 0, lvl = 0, msg = 0;
  logic glb = 0, leg = 0, tsrc = 0, csrc = 0, ack = 0;
  logic [N*RW-1:0] route = 0;
  logic [N*64-1:0] cfg = 0;
  logic [L-1:0] irq;
  logic [N-1:0] status;
  logic tmr_en, req;
  logic [31:0] addr, data;
  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  timer_irq_router u_timer_irq_router (
    .clk(clk), .rst_n(rst_n), .fire_i(fire), .clr_i(clr), .glb_en_i(glb),
    .legacy_i(leg), .ch_en_i(en), .ch_level_i(lvl), .ch_msg_en_i(msg),
    .ch_route_i(route), .ch_msg_i(cfg), .lgc_tmr_lvl_i(tsrc),
    .lgc_clk_lvl_i(csrc), .msg_ack_i(ack), .irq_o(irq), .status_o(status),
    .lgc_tmr_en_o(tmr_en), .msg_req_o(req), .msg_addr_o(addr), .msg_data_o(data));

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic pulse_fire(logic [N-1:0] m);
    fire = m; tick(); fire = 0;
  endtask

  task automatic t_reset;
    chk("R11 irq", irq, 0); chk("R11 status", status, 0);
    chk("R11 req", req, 0); chk("R11 tmr_en", tmr_en, 1);
  endtask

  task automatic t_level;
    glb = 1; en[2] = 1; lvl[2] = 1; route[2*RW +: RW] = 5;
    pulse_fire(4'b0100);
    chk("R2 status set", status[2], 1); chk("R2 line", irq, 24'h20);
    tick(3);
    chk("R2 held", irq, 24'h20);
    clr[2] = 1; tick(); clr = 0;
    chk("R4 clr status", status[2], 0); chk("R4 clr line", irq, 0);
  endtask

  task automatic t_edge;
    en[3] = 1; lvl[3] = 0; route[3*RW +: RW] = 7;
    pulse_fire(4'b1000);
    chk("R3 pulse", irq, 24'h80); chk("R3 status", status[3], 0);
    tick();
    chk("R3 one cycle", irq, 0);
  endtask

  task automatic t_disable;
    pulse_fire(4'b0100);
    chk("R4 precond", irq, 24'h20);
    glb = 0; tick();
    chk("R4 glb off status", status[2], 0); chk("R4 glb off line", irq, 0);
    pulse_fire(4'b0100);
    chk("R4 fire while off", irq, 0);
    glb = 1; pulse_fire(4'b0100);
    en[2] = 0; tick();
    chk("R4 ch off", {status[2], irq}, 0);
    en[2] = 1;
  endtask

  task automatic t_legacy;
    en[1:0] = 2'b11; lvl[1:0] = 2'b11;
    route[0 +: RW] = 3; route[RW +: RW] = 4;
    pulse_fire(4'b0001);
    chk("R1 ch0 routed", irq, 24'h8);
    clr = 4'b0001; tick(); clr = 0;
    tsrc = 1; csrc = 1; leg = 1;
    pulse_fire(4'b0111);
    chk("R1 legacy lines", irq, 24'h000121);
    chk("R7 tmr off", tmr_en, 0);
    clr = 4'b0111; tick(); clr = 0;
    chk("R7 sources muted", irq, 0);
    leg = 0; tick();
    chk("R8 tmr on", tmr_en, 1);
    chk("R8 line8 restored", irq, 24'h000101);
    csrc = 0; #1;
    chk("R9 line8 lags", irq[8], 1);
    tick();
    chk("R9 line8 follows", irq[8], 0);
    tsrc = 0; #1;
    chk("R9 line0 direct", irq[0], 0);
  endtask

  task automatic t_msg;
    en[1] = 1; lvl[1] = 1; route[RW +: RW] = 6;
    pulse_fire(4'b0010);
    chk("R6 precond", irq, 24'h40);
    msg[1] = 1; tick();
    chk("R6 cleared", {status[1], irq}, 0);
    cfg[64 +: 64] = 64'hA000_1000_DEAD_0001;
    pulse_fire(4'b0010);
    chk("R5 not yet", req, 0);
    tick();
    chk("R5 req", req, 1); chk("R5 addr", addr, 32'hA000_1000);
    chk("R5 data", data, 32'hDEAD_0001); chk("R5 no line", irq, 0);
    tick(3);
    chk("R5 held", {req, addr, data}, {1'b1, 64'hA000_1000_DEAD_0001});
    ack = 1; tick(); ack = 0;
    chk("R5 released", req, 0);
  endtask

  task automatic t_arb;
    en[3:2] = 2'b11; msg[3:2] = 2'b11;
    cfg[128 +: 64] = 64'h2222_0000_0000_0002;
    cfg[192 +: 64] = 64'h3333_0000_0000_0003;
    pulse_fire(4'b1100);
    tick();
    chk("R10 lowest first", {req, addr, data}, {1'b1, 64'h2222_0000_0000_0002});
    pulse_fire(4'b0100);
    ack = 1; tick(); ack = 0;
    chk("R10 gap", req, 0);
    tick();
    chk("R10 second", {req, addr, data}, {1'b1, 64'h3333_0000_0000_0003});
    ack = 1; tick(); ack = 0;
    tick(2);
    chk("R10 duplicate dropped", req, 0);
  endtask

  initial begin
    tick(3);
    t_reset();
    rst_n = 1; tick();
    t_level();
    t_edge();
    t_disable();
    t_legacy();
    t_msg();
    t_arb();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule